// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port on a simple register bus. Software writes an output value and a per-pin direction. It reads back the output value and the synchronized pad levels. Every pin also feeds a trigger detector. The detector can flag a low level, a high level, a rising edge or a falling edge. A per-pin override makes the pin flag on either edge instead.

Flagged events collect in a status register. Software clears a status bit by writing 1 to it. A status bit requests an interrupt only when its mask bit is also 1. Pending requests from pins 0–15 drive one interrupt line and those from pins 16–31 drive a second line. A third output is the OR of the two, for a system that wants a single line.

The bus has a word address, a write strobe, write data and a combinational read-data path. Pad inputs pass through a two-flop synchronizer before any logic uses them.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0, `pad_out` and `pad_oe` are 0 and all three interrupt outputs are low.
- R2: A write to word 0x00 sets the output value and a write to word 0x04 sets the direction. `pad_out` equals the output value and `pad_oe` equals the direction (1 = output). A read of 0x00 returns the last value written there. Neither output changes without a write to its own word.
- R3: A read of word 0x08 returns the pad levels after two clock edges of synchronization. A pad change driven before edge k is visible after edge k+1 and not after edge k alone.
- R4: Each pin has a 2-bit trigger code: 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. Pins 0–15 take their codes from word 0x0C and pins 16–31 from word 0x10. Pin n uses bits [2*(n mod 16)+1 : 2*(n mod 16)]. An edge sets the status bit one edge after it is visible in the pad status. A status bit becomes 1 only on a cycle in which its pin's trigger fired.
- R5: When bit n of word 0x1C is 1, pin n flags on both rising and falling edges and its 2-bit code is ignored. In particular, a steady level never sets the bit.
- R6: Writing 1 to a bit of the status word 0x18 clears it. Writing 0 leaves it unchanged.
- R7: In the level modes the status bit is set on every cycle the level is present. If a set and a clear reach the same bit in the same cycle, the set wins.
- R8: `irq_lo` is high when some pin in 0–15 has both its status bit and its mask bit (word 0x14) set. `irq_hi` does the same for pins 16–31. `irq_any` is their OR. With the mask at 0 no interrupt output rises.
- R9: Address bits [1:0] are ignored in decode. A write to the pad status word 0x08 has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |
| irq_lo | output | 1 | Interrupt request for pins 0–15 |
| irq_hi | output | 1 | Interrupt request for pins 16–31 |
| irq_any | output | 1 | OR of both interrupt requests |

## Verification
The hardest case to reach is a status clear that lands in the same cycle as a new set. The case matters most where a level trigger keeps firing, and where the both-edge override must keep a steady high level from ever flagging. Directed sequences build these cases. One holds a pin low in low-level mode and then writes its clear. Another raises a pin configured as high level with the override set, clears the resulting bit, and watches that it stays clear while the level persists. A reference model in the bench, stepped on every clock edge, then follows a long stream of random register writes and sparse random pad toggles. That stream mixes every trigger code, mask pattern and clear in any order.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    localparam int unsigned CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        TRIG_LEVEL_LOW  = 2'd0,
        TRIG_LEVEL_HIGH = 2'd1,
        TRIG_EDGE_RISE  = 2'd2,
        TRIG_EDGE_FALL  = 2'd3
    } trig_code_e;

    typedef enum logic [2:0] {
        SEL_DOUT   = 3'd0,
        SEL_DIR    = 3'd1,
        SEL_PADS   = 3'd2,
        SEL_CFG_LO = 3'd3,
        SEL_CFG_HI = 3'd4,
        SEL_MASK   = 3'd5,
        SEL_STAT   = 3'd6,
        SEL_BOTH   = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/gpio_pad_sync.sv
`timescale 1ns/1ps
// Synchronizer chain plus one history stage for edge detection.
module gpio_pad_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    localparam int unsigned DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = pad_i;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.pipe[STAGES-1];
    assign prev_o = st_q.pipe[STAGES];

endmodule

// File: rtl/gpio_trig_cell.sv
`timescale 1ns/1ps
// One pin's trigger decision from its current and previous sample.
module gpio_trig_cell
    import gpio_irq_pkg::*;
(
    input  logic              cur_i,
    input  logic              old_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              both_i,
    output logic              hit_o
);
    logic rise_w, fall_w;

    always_comb begin
        rise_w = cur_i & ~old_i;
        fall_w = ~cur_i & old_i;
        if (both_i) begin
            hit_o = rise_w | fall_w;
        end else begin
            case (code_i)
                TRIG_LEVEL_LOW:  hit_o = ~cur_i;
                TRIG_LEVEL_HIGH: hit_o = cur_i;
                TRIG_EDGE_RISE:  hit_o = rise_w;
                default:         hit_o = fall_w;
            endcase
        end
    end

endmodule

// File: rtl/gpio_trig_bank.sv
`timescale 1ns/1ps
// Trigger cells for all pins; codes come from the lower or upper config word.
module gpio_trig_bank
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic [NPIN-1:0]          cur_i,
    input  logic [NPIN-1:0]          old_i,
    input  logic [CODE_W*NPIN/2-1:0] cfg_lo_i,
    input  logic [CODE_W*NPIN/2-1:0] cfg_hi_i,
    input  logic [NPIN-1:0]          both_i,
    output logic [NPIN-1:0]          hit_o
);
    localparam int unsigned HALF = NPIN / 2;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic [CODE_W-1:0] code_w;
        if (g < HALF) begin : g_low
            assign code_w = cfg_lo_i[CODE_W*g +: CODE_W];
        end else begin : g_high
            assign code_w = cfg_hi_i[CODE_W*(g-HALF) +: CODE_W];
        end
        gpio_trig_cell u_cell (
            .cur_i  (cur_i[g]),
            .old_i  (old_i[g]),
            .code_i (code_w),
            .both_i (both_i[g]),
            .hit_o  (hit_o[g])
        );
    end

endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPIN        = 32,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic              irq_any
);
    localparam int unsigned HALF  = NPIN / 2;
    localparam int unsigned CFG_W = CODE_W * HALF;
    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam int unsigned NREGS = 8;

    typedef struct packed {
        logic [NPIN-1:0]  dout;
        logic [NPIN-1:0]  dir;
        logic [CFG_W-1:0] cfg_lo;
        logic [CFG_W-1:0] cfg_hi;
        logic [NPIN-1:0]  mask;
        logic [NPIN-1:0]  stat;
        logic [NPIN-1:0]  both;
    } port_regs_t;

    port_regs_t r_d, r_q;

    logic [NPIN-1:0] sync_w, prev_w, hit_w, clr_w, pend_w;
    logic [IDX_W-1:0] word_w;
    logic [31:0]      word_ext_w;
    logic             mapped_w;
    reg_sel_e         sel_w;
    logic [1:0]       unused_lsb;

    assign unused_lsb = bus_addr[1:0];
    assign word_w     = bus_addr[ADDR_W-1:2];
    assign word_ext_w = 32'(word_w);
    assign mapped_w   = word_ext_w < NREGS;
    assign sel_w      = reg_sel_e'(word_ext_w[2:0]);

    gpio_pad_sync #(
        .WIDTH  (NPIN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pad_in),
        .sync_o (sync_w),
        .prev_o (prev_w)
    );

    gpio_trig_bank #(
        .NPIN (NPIN)
    ) u_trig (
        .cur_i    (sync_w),
        .old_i    (prev_w),
        .cfg_lo_i (r_q.cfg_lo),
        .cfg_hi_i (r_q.cfg_hi),
        .both_i   (r_q.both),
        .hit_o    (hit_w)
    );

    always_comb begin
        r_d   = r_q;
        clr_w = '0;
        if (bus_we && mapped_w) begin
            case (sel_w)
                SEL_DOUT:   r_d.dout   = bus_wdata;
                SEL_DIR:    r_d.dir    = bus_wdata;
                SEL_CFG_LO: r_d.cfg_lo = bus_wdata[CFG_W-1:0];
                SEL_CFG_HI: r_d.cfg_hi = bus_wdata[CFG_W-1:0];
                SEL_MASK:   r_d.mask   = bus_wdata;
                SEL_STAT:   clr_w      = bus_wdata;
                SEL_BOTH:   r_d.both   = bus_wdata;
                default:    ;
            endcase
        end
        // a fresh trigger overrides a clear in the same cycle
        r_d.stat = (r_q.stat & ~clr_w) | hit_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (mapped_w) begin
            case (sel_w)
                SEL_DOUT:   bus_rdata = r_q.dout;
                SEL_DIR:    bus_rdata = r_q.dir;
                SEL_PADS:   bus_rdata = sync_w;
                SEL_CFG_LO: bus_rdata = NPIN'(r_q.cfg_lo);
                SEL_CFG_HI: bus_rdata = NPIN'(r_q.cfg_hi);
                SEL_MASK:   bus_rdata = r_q.mask;
                SEL_STAT:   bus_rdata = r_q.stat;
                default:    bus_rdata = r_q.both;
            endcase
        end
    end

    assign pad_out = r_q.dout;
    assign pad_oe  = r_q.dir;
    assign pend_w  = r_q.stat & r_q.mask;
    assign irq_lo  = |pend_w[HALF-1:0];
    assign irq_hi  = |pend_w[NPIN-1:HALF];
    assign irq_any = irq_lo | irq_hi;

    AST_STAT_ONLY_ON_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.stat & ~$past(r_q.stat) & ~$past(hit_w)) == '0)); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && mapped_w && sel_w == SEL_STAT)
        |=> ((r_q.stat & $past(bus_wdata & ~hit_w)) == '0)); // R6

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~r_q.stat & $past(hit_w)) == '0)); // R7

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mask == '0) |-> !irq_any); // R8

    AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && mapped_w && sel_w == SEL_DOUT) |=> $stable(pad_out)); // R2

    AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && mapped_w && sel_w == SEL_DIR) |=> $stable(pad_oe)); // R2

endmodule

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_lo, irq_hi, irq_any;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    gpio_irq_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_lo    (irq_lo),
        .irq_hi    (irq_hi),
        .irq_any   (irq_any)
    );

    // reference model state
    logic [31:0] m_s1, m_sync, m_prev, m_dout, m_dir, m_cl, m_ch, m_mask, m_stat, m_both;

    function automatic logic [31:0] ref_hits(input logic [31:0] cur, input logic [31:0] old,
                                             input logic [31:0] cl, input logic [31:0] ch,
                                             input logic [31:0] bo);
        logic [31:0] h;
        logic [1:0]  c;
        h = '0;
        for (int n = 0; n < 32; n++) begin
            c = (n < 16) ? cl[2*n +: 2] : ch[2*(n-16) +: 2];
            if (bo[n])        h[n] = cur[n] ^ old[n];
            else if (c == 0)  h[n] = ~cur[n];
            else if (c == 1)  h[n] = cur[n];
            else if (c == 2)  h[n] = cur[n] & ~old[n];
            else              h[n] = ~cur[n] & old[n];
        end
        return h;
    endfunction

    function automatic logic [31:0] ref_read(input logic [4:0] a);
        case (a[4:2])
            3'd0: return m_dout;
            3'd1: return m_dir;
            3'd2: return m_sync;
            3'd3: return m_cl;
            3'd4: return m_ch;
            3'd5: return m_mask;
            3'd6: return m_stat;
            default: return m_both;
        endcase
    endfunction

    task automatic model_reset();
        m_s1 = '0; m_sync = '0; m_prev = '0; m_dout = '0; m_dir = '0;
        m_cl = '0; m_ch = '0; m_mask = '0; m_stat = '0; m_both = '0;
    endtask

    task automatic model_step();
        logic [31:0] h, clr;
        h = ref_hits(m_sync, m_prev, m_cl, m_ch, m_both);
        clr = '0;
        if (bus_we) begin
            case (bus_addr[4:2])
                3'd0: m_dout = bus_wdata;
                3'd1: m_dir  = bus_wdata;
                3'd3: m_cl   = bus_wdata;
                3'd4: m_ch   = bus_wdata;
                3'd5: m_mask = bus_wdata;
                3'd6: clr    = bus_wdata;
                3'd7: m_both = bus_wdata;
                default: ;
            endcase
        end
        m_stat = (m_stat & ~clr) | h;
        m_prev = m_sync;
        m_sync = m_s1;
        m_s1   = pad_in;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [31:0] pend;
        pend = m_stat & m_mask;
        chk("R2 pad_out", pad_out, m_dout);
        chk("R2 pad_oe", pad_oe, m_dir);
        chk("R8 irq", {29'd0, irq_any, irq_hi, irq_lo},
            {29'd0, |pend, |pend[31:16], |pend[15:0]});
        chk("R9 rdata", bus_rdata, ref_read(bus_addr));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        compare();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: all registers zero before the first edge after reset
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), v);
            chk("R1 reset read", v, 32'd0);
        end
        chk("R1 reset outputs", {pad_out | pad_oe, 29'd0, irq_any, irq_hi, irq_lo}, '0);

        // all pins to rising-edge mode, clear the low-level flags raised after reset
        wr(5'h0C, 32'hAAAA_AAAA);
        wr(5'h10, 32'hAAAA_AAAA);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, v);
        chk("R6 clear all", v, 32'd0);

        // R2: output value and direction
        wr(5'h00, 32'h1234_5678);
        wr(5'h04, 32'hFFFF_0000);
        chk("R2 pad_out", pad_out, 32'h1234_5678);
        chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);
        rd(5'h00, v);
        chk("R2 readback", v, 32'h1234_5678);

        // R9: write to pad status word ignored, byte lane bits ignored
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, v);
        chk("R9 pad word write ignored", v, 32'd0);
        wr(5'h17, 32'h0010_0008);
        rd(5'h15, v);
        chk("R9 lsb ignored", v, 32'h0010_0008);

        // R3: two-edge synchronization of pin 3
        pad_in = 32'h0000_0008;
        tick();
        rd(5'h08, v);
        chk("R3 after one edge", v, 32'd0);
        tick();
        rd(5'h08, v);
        chk("R3 after two edges", v, 32'h0000_0008);
        rd(5'h18, v);
        chk("R4 not yet flagged", v, 32'd0);
        tick();
        rd(5'h18, v);
        chk("R4 rising flagged", v, 32'h0000_0008);
        chk("R8 irq_lo", {30'd0, irq_hi, irq_lo}, 32'd1);

        // R6: write 0 keeps, write 1 clears
        wr(5'h18, 32'd0);
        rd(5'h18, v);
        chk("R6 write zero", v, 32'h0000_0008);
        wr(5'h18, 32'h0000_0008);
        rd(5'h18, v);
        chk("R6 write one", v, 32'd0);
        chk("R8 irq dropped", {31'd0, irq_any}, 32'd0);

        // R4: falling-edge code on pin 20
        wr(5'h10, 32'hAAAA_AAAA | 32'h0000_0100);
        pad_in = 32'h0010_0008;
        ticks(3);
        rd(5'h18, v);
        chk("R4 fall ignores rise", v, 32'd0);
        pad_in = 32'h0000_0008;
        ticks(3);
        rd(5'h18, v);
        chk("R4 falling flagged", v, 32'h0010_0000);
        chk("R8 irq_hi", {30'd0, irq_hi, irq_lo}, 32'd2);

        // R5: both-edge override on pin 17 configured as high level
        wr(5'h18, 32'h0010_0000);
        wr(5'h1C, 32'h0002_0000);
        wr(5'h10, 32'hAAAA_ABA6);
        pad_in = 32'h0002_0008;
        ticks(3);
        rd(5'h18, v);
        chk("R5 rise flagged", v, 32'h0002_0000);
        wr(5'h18, 32'h0002_0000);
        ticks(3);
        rd(5'h18, v);
        chk("R5 steady level ignored", v, 32'd0);
        pad_in = 32'h0000_0008;
        ticks(3);
        rd(5'h18, v);
        chk("R5 fall flagged", v, 32'h0002_0000);

        // R7: low level on pin 5 re-sets, and set wins over clear
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h0C, 32'hAAAA_A2AA);
        rd(5'h18, v);
        chk("R7 before level", v, 32'd0);
        tick();
        rd(5'h18, v);
        chk("R7 level flagged", v, 32'h0000_0020);
        wr(5'h18, 32'h0000_0020);
        rd(5'h18, v);
        chk("R7 set wins", v, 32'h0000_0020);

        // random phase against the reference model
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 4 == 0) pad_in = pad_in ^ ($urandom & $urandom & $urandom);
            bus_we    = ($urandom % 3 == 0);
            bus_addr  = 5'($urandom);
            bus_wdata = $urandom;
            tick();
        end
        bus_we = 1'b0;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule